// File: doc/BRIEF.md
# RV32I Single-Cycle Control Decoder

This block is the control unit of a processor that finishes one instruction per clock. It is purely combinational. It looks at a 32-bit base-integer instruction and at two flags from the branch comparator, equal and less-than. From these it drives every select line the datapath needs:

- the immediate format;
- the register-file write enable;
- the signed or unsigned compare request;
- the two ALU operand selects;
- the ALU operation;
- the data-memory write strobe;
- the writeback source;
- the next-PC source.

It handles register-register and register-immediate arithmetic, loads, stores, the six conditional branches, JAL and JALR. It decides branch outcomes itself. When the comparator is given the two source registers, the flags come back in the same cycle, and the decoder picks the branch target only when the condition holds.

Any opcode outside that set gives a bubble: no register write, no memory write, and sequential fetch.

Top module: `rv32i_ctrl_decode`

## Requirements
- R1: For opcode 0110011 the outputs are `a_sel`=0 (rs1), `b_sel`=0 (rs2), `reg_wen`=1, `mem_wr`=0, `wb_sel`=1 (ALU) and `pc_sel`=0 (PC+4). `alu_op` follows funct3 (inst[14:12]) as 0:ADD(0), 1:SLL(2), 2:SLT(3), 3:SLTU(4), 4:XOR(5), 5:SRL(6), 6:OR(8), 7:AND(9). When inst[30]=1, funct3 0 gives SUB(1) and funct3 5 gives SRA(7).
- R2: For opcode 0010011 the outputs are `imm_sel`=0 (I), `a_sel`=0, `b_sel`=1 (immediate), `reg_wen`=1, `mem_wr`=0, `wb_sel`=1 and `pc_sel`=0. `alu_op` uses the R1 table, except that inst[30] changes only funct3 5 (to SRA). Funct3 0 always gives ADD.
- R3: For opcode 0000011 the outputs are `imm_sel`=0, `a_sel`=0, `b_sel`=1, `alu_op`=ADD, `mem_wr`=0, `reg_wen`=1, `wb_sel`=0 (memory data) and `pc_sel`=0.
- R4: For opcode 0100011 the outputs are `imm_sel`=1 (S), `a_sel`=0, `b_sel`=1, `alu_op`=ADD, `mem_wr`=1, `reg_wen`=0 and `pc_sel`=0. `wb_sel` is unconstrained.
- R5: For opcode 1100011 with a valid funct3 the outputs are `imm_sel`=2 (B), `a_sel`=1 (PC), `b_sel`=1, `alu_op`=ADD, `reg_wen`=0 and `mem_wr`=0.
- R6: A branch sets `pc_sel`=1 (ALU target) only when its condition holds, and 0 otherwise:
  - funct3 0: `br_eq`
  - funct3 1: !`br_eq`
  - funct3 4 and 6: `br_lt`
  - funct3 5 and 7: !`br_lt`
- R7: `br_un` is 1 only for branches with funct3 6 or 7, and 0 for every other instruction.
- R8: For opcode 1100111 the outputs are `imm_sel`=0, `a_sel`=0, `b_sel`=1, `alu_op`=ADD, `reg_wen`=1, `mem_wr`=0, `wb_sel`=2 (PC+4) and `pc_sel`=1.
- R9: For opcode 1101111 the outputs are `imm_sel`=3 (J), `a_sel`=1, `b_sel`=1, `alu_op`=ADD, `reg_wen`=1, `mem_wr`=0, `wb_sel`=2 and `pc_sel`=1.
- R10: Any other opcode, or a branch opcode with funct3 2 or 3, gives `reg_wen`=0, `mem_wr`=0 and `pc_sel`=0, whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst | input | 32 | Instruction being executed |
| br_eq | input | 1 | Comparator: operands equal |
| br_lt | input | 1 | Comparator: A less than B |
| imm_sel | output | 2 | Immediate format: 0 I, 1 S, 2 B, 3 J |
| reg_wen | output | 1 | Register-file write enable |
| br_un | output | 1 | Request an unsigned compare |
| a_sel | output | 1 | ALU A source: 0 rs1, 1 PC |
| b_sel | output | 1 | ALU B source: 0 rs2, 1 immediate |
| alu_op | output | 4 | ALU operation code |
| mem_wr | output | 1 | Data memory: 1 write, 0 read |
| wb_sel | output | 2 | Writeback: 0 memory, 1 ALU, 2 PC+4 |
| pc_sel | output | 1 | Next PC: 0 PC+4, 1 ALU result |

## Verification
The decoder holds no state, so every output is due in the same cycle as the instruction and flags that produce it, with zero register stages. The bench drives a new instruction and new flags just after each rising edge. It compares all outputs against its own model at the following falling edge, after the inputs have settled and before the next change. Branch vectors are repeated with every combination of the two flags, so each condition is seen both taken and not taken.

// File: rtl/rv32i_ctrl_decode.sv
module rv32i_ctrl_decode (
  input  logic [31:0] inst,
  input  logic        br_eq,
  input  logic        br_lt,
  output logic [1:0]  imm_sel,
  output logic        reg_wen,
  output logic        br_un,
  output logic        a_sel,
  output logic        b_sel,
  output logic [3:0]  alu_op,
  output logic        mem_wr,
  output logic [1:0]  wb_sel,
  output logic        pc_sel
);

  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  localparam logic [1:0] IMM_I = 2'd0, IMM_S = 2'd1, IMM_B = 2'd2, IMM_J = 2'd3;
  localparam logic [1:0] WB_MEM = 2'd0, WB_ALU = 2'd1, WB_PC4 = 2'd2;

  localparam logic [3:0] ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_SLL = 4'd2, ALU_SLT = 4'd3,
                         ALU_SLTU = 4'd4, ALU_XOR = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
                         ALU_OR = 4'd8, ALU_AND = 4'd9;

  wire [6:0] opc = inst[6:0];
  wire [2:0] f3  = inst[14:12];
  wire       alt = inst[30];

  function automatic logic [3:0] arith_op(input logic [2:0] fn, input logic alt_bit, input logic sub_ok);
    case (fn)
      3'd0:    arith_op = (sub_ok && alt_bit) ? ALU_SUB : ALU_ADD;
      3'd1:    arith_op = ALU_SLL;
      3'd2:    arith_op = ALU_SLT;
      3'd3:    arith_op = ALU_SLTU;
      3'd4:    arith_op = ALU_XOR;
      3'd5:    arith_op = alt_bit ? ALU_SRA : ALU_SRL;
      3'd6:    arith_op = ALU_OR;
      default: arith_op = ALU_AND;
    endcase
  endfunction

  logic taken;
  always_comb begin
    case (f3)
      3'd0:    taken = br_eq;
      3'd1:    taken = !br_eq;
      3'd4,
      3'd6:    taken = br_lt;
      3'd5,
      3'd7:    taken = !br_lt;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    imm_sel = IMM_I;
    reg_wen = 1'b0;
    br_un   = 1'b0;
    a_sel   = 1'b0;
    b_sel   = 1'b0;
    alu_op  = ALU_ADD;
    mem_wr  = 1'b0;
    wb_sel  = WB_ALU;
    pc_sel  = 1'b0;
    case (opc)
      OPC_OP: begin
        reg_wen = 1'b1;
        alu_op  = arith_op(f3, alt, 1'b1);
      end
      OPC_OPIMM: begin
        b_sel   = 1'b1;
        reg_wen = 1'b1;
        alu_op  = arith_op(f3, alt, 1'b0);
      end
      OPC_LOAD: begin
        b_sel   = 1'b1;
        reg_wen = 1'b1;
        wb_sel  = WB_MEM;
      end
      OPC_STORE: begin
        imm_sel = IMM_S;
        b_sel   = 1'b1;
        mem_wr  = 1'b1;
      end
      OPC_BRANCH: begin
        imm_sel = IMM_B;
        a_sel   = 1'b1;
        b_sel   = 1'b1;
        br_un   = f3[2] & f3[1];
        pc_sel  = taken;
      end
      OPC_JALR: begin
        b_sel   = 1'b1;
        reg_wen = 1'b1;
        wb_sel  = WB_PC4;
        pc_sel  = 1'b1;
      end
      OPC_JAL: begin
        imm_sel = IMM_J;
        a_sel   = 1'b1;
        b_sel   = 1'b1;
        reg_wen = 1'b1;
        wb_sel  = WB_PC4;
        pc_sel  = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    AST_STORE_NO_REGWRITE: assert (!(mem_wr && reg_wen));                                                   // R4
    AST_BRUN_ONLY_BRANCH:  assert (!br_un || opc == OPC_BRANCH);                                            // R7
    AST_REDIRECT_ONLY_CTRL: assert (!pc_sel || opc == OPC_BRANCH || opc == OPC_JAL || opc == OPC_JALR);     // R6
    AST_LINK_IMPLIES_JUMP: assert (wb_sel != WB_PC4 || (pc_sel && reg_wen));                                // R8
    AST_UNKNOWN_BUBBLE:    assert (!(reg_wen || mem_wr || pc_sel) || opc inside {OPC_OP, OPC_OPIMM, OPC_LOAD,
                                   OPC_STORE, OPC_BRANCH, OPC_JAL, OPC_JALR});                              // R10
  end

endmodule

// File: tb/tb_rv32i_ctrl_decode.sv
module tb_rv32i_ctrl_decode;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] inst = 32'h0;
  logic br_eq = 1'b0, br_lt = 1'b0;
  logic [1:0] imm_sel, wb_sel;
  logic reg_wen, br_un, a_sel, b_sel, mem_wr, pc_sel;
  logic [3:0] alu_op;

  int checks = 0, errors = 0;

  rv32i_ctrl_decode dut (.inst(inst), .br_eq(br_eq), .br_lt(br_lt), .imm_sel(imm_sel), .reg_wen(reg_wen),
    .br_un(br_un), .a_sel(a_sel), .b_sel(b_sel), .alu_op(alu_op), .mem_wr(mem_wr), .wb_sel(wb_sel), .pc_sel(pc_sel));

  always #2 clk = ~clk;

  int e_imm, e_wen, e_un, e_a, e_b, e_alu, e_mw, e_wb, e_pc;
  bit c_imm, c_a, c_b, c_alu, c_wb;
  string tag, pc_tag;

  task automatic model(input logic [31:0] i, input logic eq, input logic lt);
    int tab[8] = '{0, 2, 3, 4, 5, 6, 8, 9};
    int fn = int'(i[14:12]);
    e_imm = 0; e_wen = 0; e_un = 0; e_a = 0; e_b = 0; e_alu = 0; e_mw = 0; e_wb = 1; e_pc = 0;
    c_imm = 1; c_a = 1; c_b = 1; c_alu = 1; c_wb = 1;
    pc_tag = "";
    if (i[6:0] == 7'h33) begin
      tag = "R1"; e_wen = 1; c_imm = 0;
      e_alu = tab[fn];
      if (fn == 0 && i[30]) e_alu = 1;
      if (fn == 5 && i[30]) e_alu = 7;
    end else if (i[6:0] == 7'h13) begin
      tag = "R2"; e_wen = 1; e_b = 1;
      e_alu = tab[fn];
      if (fn == 5 && i[30]) e_alu = 7;
    end else if (i[6:0] == 7'h03) begin
      tag = "R3"; e_wen = 1; e_b = 1; e_wb = 0;
    end else if (i[6:0] == 7'h23) begin
      tag = "R4"; e_imm = 1; e_b = 1; e_mw = 1; c_wb = 0;
    end else if (i[6:0] == 7'h63 && fn != 2 && fn != 3) begin
      tag = "R5"; pc_tag = "R6"; e_imm = 2; e_a = 1; e_b = 1; c_wb = 0;
      e_un = (fn >= 6) ? 1 : 0;
      if (fn == 0) e_pc = eq;
      else if (fn == 1) e_pc = !eq;
      else if (fn == 4 || fn == 6) e_pc = lt;
      else e_pc = !lt;
    end else if (i[6:0] == 7'h67) begin
      tag = "R8"; e_wen = 1; e_b = 1; e_wb = 2; e_pc = 1;
    end else if (i[6:0] == 7'h6f) begin
      tag = "R9"; e_imm = 3; e_a = 1; e_b = 1; e_wen = 1; e_wb = 2; e_pc = 1;
    end else begin
      tag = "R10"; c_imm = 0; c_a = 0; c_b = 0; c_alu = 0; c_wb = 0;
    end
    if (pc_tag == "") pc_tag = tag;
  endtask

  task automatic cmp(input string t, input string nm, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s inst=%h eq=%0b lt=%0b: got %0d expected %0d", t, nm, inst, br_eq, br_lt, got, exp);
    end
  endtask

  task automatic check_now();
    model(inst, br_eq, br_lt);
    if (c_imm) cmp(tag, "imm_sel", imm_sel, e_imm);
    if (c_a)   cmp(tag, "a_sel", a_sel, e_a);
    if (c_b)   cmp(tag, "b_sel", b_sel, e_b);
    if (c_alu) cmp(tag, "alu_op", alu_op, e_alu);
    if (c_wb)  cmp(tag, "wb_sel", wb_sel, e_wb);
    cmp(tag, "reg_wen", reg_wen, e_wen);
    cmp(tag, "mem_wr", mem_wr, e_mw);
    cmp(pc_tag, "pc_sel", pc_sel, e_pc);
    cmp("R7", "br_un", br_un, e_un);
  endtask

  task automatic apply(input logic [31:0] i, input logic eq, input logic lt);
    @(posedge clk);
    inst = i; br_eq = eq; br_lt = lt;
    @(negedge clk);
    check_now();
  endtask

  task automatic apply_flags(input logic [31:0] i);
    for (int k = 0; k < 4; k++) apply(i, k[1], k[0]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now();                                  // R10: reset state, all-zero word is a bubble
    rst = 1'b0;
    apply(32'h003100b3, 0, 0);                    // R1 add
    apply(32'h403100b3, 0, 0);                    // R1 sub
    apply(32'h403150b3, 0, 0);                    // R1 sra
    apply(32'h003170b3, 0, 0);                    // R1 and
    apply(32'hfce08793, 0, 0);                    // R2 addi -50
    apply(32'h40008093, 0, 0);                    // R2 addi with bit 30 set stays ADD
    apply(32'h4030d093, 0, 0);                    // R2 srai
    apply(32'h0030d093, 0, 0);                    // R2 srli
    apply(32'h00812703, 1, 1);                    // R3 lw
    apply(32'h00e12423, 1, 0);                    // R4 sw
    for (int f = 0; f < 8; f++)                   // R5 R6 R7 all funct3, R10 for 2 and 3
      apply_flags(32'h00208063 | (32'(f) << 12));
    apply_flags(32'h000080e7);                    // R8 jalr
    apply_flags(32'h008000ef);                    // R9 jal
    apply_flags(32'h0000007f);                    // R10 unknown
    apply_flags(32'h123450b7);                    // R10 lui is outside the set
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] ops[9] = '{7'h33, 7'h13, 7'h03, 7'h23, 7'h63, 7'h67, 7'h6f, 7'h37, 7'h0f};
      logic [31:0] w = $urandom;
      int sel = $urandom_range(0, 9);
      if (sel < 9) w[6:0] = ops[sel];
      apply(w, 1'($urandom), 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule